// File: doc/BRIEF.md
# Redundant Thread Load/Store Checker

This block sits between a pair of redundant copies of one thread and the memory system, and detects transient faults by comparing what the two copies do. Only the leading copy reads the data cache. Each value it loads is written into an ordered load value queue together with its address. The trailing copy never touches the cache. It takes its load data from the head of that queue, and it presents its own load address, which is compared with the address stored in the queue.

Stores from the leading copy are held in a store queue. A store leaves the block only when the trailing copy commits its matching store. If the address and data of the two stores agree, exactly one memory write is issued. If they disagree, no write is issued and a sticky fault is raised. In both cases the queue entry is freed. The fault record keeps the kind of the first fault and the address that was offending until software-independent logic pulses the clear input.

Top module: `rt_lsq_checker`

## Requirements
- R1: After reset, both leading ready outputs are 1, both trailing ready outputs are 0, mem_wr_valid is 0 and fault is 0.
- R2: The trailing thread receives load data on trail_ld_data in the same order in which the leading thread loaded it.
- R3: trail_ld_ready is 0 whenever the load queue is empty. A trailing load offered while it is 0 changes nothing: the next value queued afterwards is the next one delivered.
- R4: lead_ld_ready is 0 while the load queue holds LVQ_DEPTH entries. A leading load offered then is dropped and is never delivered.
- R5: A trailing load whose address differs from the queued address sets fault in the next cycle, with fault_kind 2'b01 and fault_addr equal to the trailing address.
- R6: A trailing store whose address and data equal those of the oldest queued leading store produces exactly one cycle of mem_wr_valid in the next cycle, carrying that address and data.
- R7: A trailing store that differs in address or data produces no write. It sets fault in the next cycle with fault_kind 2'b10 and fault_addr equal to the trailing store address, and it frees the entry.
- R8: lead_st_ready is 0 while the store queue holds SQ_DEPTH entries.
- R9: trail_st_ready is 0 while the store queue is empty. A trailing store offered then produces no memory write.
- R10: The fault record is sticky. Later faults do not change fault_kind or fault_addr, and fault_clr clears fault in the next cycle. A fault event that arrives in the same cycle as fault_clr is recorded.
- R11: Matched stores are written to memory in the order in which the leading thread issued them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_ld_valid | input | 1 | Leading thread presents a completed load |
| lead_ld_addr | input | 32 | Address of the leading load |
| lead_ld_data | input | 32 | Value returned by the cache |
| lead_ld_ready | output | 1 | Load queue has room |
| trail_ld_valid | input | 1 | Trailing thread requests its next load value |
| trail_ld_addr | input | 32 | Address computed by the trailing thread |
| trail_ld_ready | output | 1 | A queued value is available |
| trail_ld_data | output | 32 | Oldest queued load value |
| lead_st_valid | input | 1 | Leading thread commits a store |
| lead_st_addr | input | 32 | Leading store address |
| lead_st_data | input | 32 | Leading store data |
| lead_st_ready | output | 1 | Store queue has room |
| trail_st_valid | input | 1 | Trailing thread commits a store |
| trail_st_addr | input | 32 | Trailing store address |
| trail_st_data | input | 32 | Trailing store data |
| trail_st_ready | output | 1 | A leading store is waiting for comparison |
| mem_wr_valid | output | 1 | Verified memory write |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 32 | Write data |
| fault_clr | input | 1 | Clears the sticky fault record |
| fault | output | 1 | Sticky fault flag |
| fault_kind | output | 2 | 01 load address mismatch, 10 store mismatch |
| fault_addr | output | 32 | Trailing address of the first recorded fault |

## Verification
Full queues are the hardest states to reach from the ports. The bench reaches them by filling a reduced four-entry configuration at every fill level from one to full, then offering one more leading access that must be dropped. A second hard case is a fault that coincides with a clear. The bench drives fault_clr in the same cycle as a mismatching trailing load, after a first fault has already been latched. Store mismatches are swept over several flipped address bits and data bits, to confirm that each one suppresses the write and still frees the entry.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } acc_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_LOAD  = 2'b01,
        FLT_STORE = 2'b10
    } flt_kind_e;

    function automatic logic acc_equal(input acc_t a, input acc_t b);
        return (a.addr == b.addr) && (a.data == b.data);
    endfunction

endpackage

// File: rtl/rtc_fifo.sv
module rtc_fifo
    import rtc_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  acc_t push_val,
    input  logic pop,
    output acc_t head,
    output logic full,
    output logic empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    acc_t           mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4 / R8: occupancy never exceeds the depth, a full queue stays full without a pop
    p_depth_bound_r4: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);
    // R3 / R9: popping an empty queue leaves it empty
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/rtc_fault_reg.sv
module rtc_fault_reg
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  flt_kind_e         ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              clr,
    output logic              flag,
    output flt_kind_e         kind,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            kind <= FLT_NONE;
            addr <= '0;
        end else if (ev_valid && (!flag || clr)) begin
            flag <= 1'b1;
            kind <= ev_kind;
            addr <= ev_addr;
        end else if (clr) begin
            flag <= 1'b0;
            kind <= FLT_NONE;
            addr <= '0;
        end
    end

    // R10: without a clear the record holds its contents
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> (flag && addr == $past(addr) && kind == $past(kind)));
    // R10: an event in a clear cycle is still recorded
    p_clr_event_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && ev_valid) |=> flag);
endmodule

// File: rtl/rt_lsq_checker.sv
module rt_lsq_checker
    import rtc_pkg::*;
#(
    parameter int LVQ_DEPTH = 64,
    parameter int SQ_DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lead_ld_valid,
    input  logic [ADDR_W-1:0] lead_ld_addr,
    input  logic [DATA_W-1:0] lead_ld_data,
    output logic              lead_ld_ready,
    input  logic              trail_ld_valid,
    input  logic [ADDR_W-1:0] trail_ld_addr,
    output logic              trail_ld_ready,
    output logic [DATA_W-1:0] trail_ld_data,
    input  logic              lead_st_valid,
    input  logic [ADDR_W-1:0] lead_st_addr,
    input  logic [DATA_W-1:0] lead_st_data,
    output logic              lead_st_ready,
    input  logic              trail_st_valid,
    input  logic [ADDR_W-1:0] trail_st_addr,
    input  logic [DATA_W-1:0] trail_st_data,
    output logic              trail_st_ready,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              fault_clr,
    output logic              fault,
    output logic [1:0]        fault_kind,
    output logic [ADDR_W-1:0] fault_addr
);
    acc_t      lvq_head, sq_head, trail_st;
    logic      lvq_full, lvq_empty, sq_full, sq_empty;
    logic      ld_fire, st_fire, ld_mis, st_match;
    logic      ev_valid;
    flt_kind_e ev_kind, rec_kind;
    logic [ADDR_W-1:0] ev_addr;

    rtc_fifo #(.DEPTH(LVQ_DEPTH)) u_lvq (
        .clk(clk), .rst(rst),
        .push(lead_ld_valid),
        .push_val('{addr: lead_ld_addr, data: lead_ld_data}),
        .pop(trail_ld_valid),
        .head(lvq_head), .full(lvq_full), .empty(lvq_empty)
    );

    rtc_fifo #(.DEPTH(SQ_DEPTH)) u_sq (
        .clk(clk), .rst(rst),
        .push(lead_st_valid),
        .push_val('{addr: lead_st_addr, data: lead_st_data}),
        .pop(trail_st_valid),
        .head(sq_head), .full(sq_full), .empty(sq_empty)
    );

    assign lead_ld_ready  = !lvq_full;
    assign trail_ld_ready = !lvq_empty;
    assign trail_ld_data  = lvq_head.data;
    assign lead_st_ready  = !sq_full;
    assign trail_st_ready = !sq_empty;

    assign trail_st = '{addr: trail_st_addr, data: trail_st_data};
    assign ld_fire  = trail_ld_valid && !lvq_empty;
    assign st_fire  = trail_st_valid && !sq_empty;
    assign ld_mis   = ld_fire && (lvq_head.addr != trail_ld_addr);
    assign st_match = acc_equal(sq_head, trail_st);

    always_comb begin
        ev_valid = 1'b0;
        ev_kind  = FLT_NONE;
        ev_addr  = '0;
        if (ld_mis) begin
            ev_valid = 1'b1;
            ev_kind  = FLT_LOAD;
            ev_addr  = trail_ld_addr;
        end else if (st_fire && !st_match) begin
            ev_valid = 1'b1;
            ev_kind  = FLT_STORE;
            ev_addr  = trail_st_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_wr_valid <= 1'b0;
            mem_wr_addr  <= '0;
            mem_wr_data  <= '0;
        end else begin
            mem_wr_valid <= st_fire && st_match;
            if (st_fire && st_match) begin
                mem_wr_addr <= sq_head.addr;
                mem_wr_data <= sq_head.data;
            end
        end
    end

    rtc_fault_reg u_fault (
        .clk(clk), .rst(rst),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
        .clr(fault_clr),
        .flag(fault), .kind(rec_kind), .addr(fault_addr)
    );
    assign fault_kind = rec_kind;

    // R6: every write follows an accepted trailing store with the same address and data
    p_write_matches_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> ($past(trail_st_valid && trail_st_ready)
                          && mem_wr_addr == $past(trail_st_addr)
                          && mem_wr_data == $past(trail_st_data)));
    // R9: no write without a waiting leading store
    p_no_write_empty_r9: assert property (@(posedge clk) disable iff (rst)
        !trail_st_ready |=> !mem_wr_valid);
    // R5: a trailing load address mismatch raises the fault
    p_ld_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (trail_ld_valid && trail_ld_ready && trail_ld_addr != lvq_head.addr) |=> fault);
    // R7: a mismatching store never writes
    p_st_mis_r7: assert property (@(posedge clk) disable iff (rst)
        (trail_st_valid && trail_st_ready && !st_match) |=> (!mem_wr_valid && fault));
endmodule

// File: tb/test_rt_lsq_checker.sv
module test_rt_lsq_checker;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lead_ld_valid = 0, trail_ld_valid = 0, lead_st_valid = 0, trail_st_valid = 0;
    logic [31:0] lead_ld_addr = 0, lead_ld_data = 0, trail_ld_addr = 0;
    logic [31:0] lead_st_addr = 0, lead_st_data = 0, trail_st_addr = 0, trail_st_data = 0;
    logic        fault_clr = 0;
    logic        lead_ld_ready, trail_ld_ready, lead_st_ready, trail_st_ready;
    logic [31:0] trail_ld_data, mem_wr_addr, mem_wr_data, fault_addr;
    logic        mem_wr_valid, fault;
    logic [1:0]  fault_kind;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rt_lsq_checker #(.LVQ_DEPTH(D), .SQ_DEPTH(D)) i_rt_lsq_checker (
        .clk(clk), .rst(rst),
        .lead_ld_valid(lead_ld_valid), .lead_ld_addr(lead_ld_addr), .lead_ld_data(lead_ld_data),
        .lead_ld_ready(lead_ld_ready),
        .trail_ld_valid(trail_ld_valid), .trail_ld_addr(trail_ld_addr),
        .trail_ld_ready(trail_ld_ready), .trail_ld_data(trail_ld_data),
        .lead_st_valid(lead_st_valid), .lead_st_addr(lead_st_addr), .lead_st_data(lead_st_data),
        .lead_st_ready(lead_st_ready),
        .trail_st_valid(trail_st_valid), .trail_st_addr(trail_st_addr), .trail_st_data(trail_st_data),
        .trail_st_ready(trail_st_ready),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .fault_clr(fault_clr), .fault(fault), .fault_kind(fault_kind), .fault_addr(fault_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        lead_ld_valid = 0; trail_ld_valid = 0; lead_st_valid = 0; trail_st_valid = 0;
        fault_clr = 0;
    endtask

    task automatic lead_load(input logic [31:0] a, input logic [31:0] d);
        lead_ld_valid = 1; lead_ld_addr = a; lead_ld_data = d;
        step();
    endtask

    task automatic lead_store(input logic [31:0] a, input logic [31:0] d);
        lead_st_valid = 1; lead_st_addr = a; lead_st_data = d;
        step();
    endtask

    task automatic clear_fault();
        fault_clr = 1;
        step();
        check("R10 clear", {63'd0, fault}, 64'd0);
    endtask

    function automatic logic [31:0] ld_addr(input int n, input int i);
        return 32'h1000 + 32'(n * 64 + i * 4);
    endfunction
    function automatic logic [31:0] ld_val(input int n, input int i);
        return 32'hA000_0000 + 32'(n * 16 + i);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        check("R1 lead_ld_ready", {63'd0, lead_ld_ready}, 64'd1);
        check("R1 lead_st_ready", {63'd0, lead_st_ready}, 64'd1);
        check("R1 trail_ld_ready", {63'd0, trail_ld_ready}, 64'd0);
        check("R1 trail_st_ready", {63'd0, trail_st_ready}, 64'd0);
        check("R1 mem_wr_valid", {63'd0, mem_wr_valid}, 64'd0);
        check("R1 fault", {63'd0, fault}, 64'd0);

        // Load queue sweep over every fill level
        for (int n = 1; n <= D; n++) begin
            for (int i = 0; i < n; i++) lead_load(ld_addr(n, i), ld_val(n, i));
            check("R4 ready level", {63'd0, lead_ld_ready}, (n == D) ? 64'd0 : 64'd1);
            if (n == D) lead_load(32'hFFF0, 32'hDEAD_BEEF); // R4 dropped
            for (int i = 0; i < n; i++) begin
                check("R3 ready nonempty", {63'd0, trail_ld_ready}, 64'd1);
                check("R2 order", {32'd0, trail_ld_data}, {32'd0, ld_val(n, i)});
                trail_ld_valid = 1; trail_ld_addr = ld_addr(n, i);
                step();
            end
            check("R3 empty", {63'd0, trail_ld_ready}, 64'd0);
            check("R5 no fault on match", {63'd0, fault}, 64'd0);
        end
        // R3: a trailing load on an empty queue changes nothing
        trail_ld_valid = 1; trail_ld_addr = 32'h7777;
        step();
        check("R3 no fault on empty", {63'd0, fault}, 64'd0);
        lead_load(32'h2000, 32'h1234_5678);
        check("R3 next value", {32'd0, trail_ld_data}, 64'h1234_5678);
        check("R4 dropped gone", {32'd0, trail_ld_data}, 64'h1234_5678);
        trail_ld_valid = 1; trail_ld_addr = 32'h2000;
        step();

        // Store queue sweep over every fill level
        for (int n = 1; n <= D; n++) begin
            for (int i = 0; i < n; i++) lead_store(ld_addr(n, i) + 32'h8000, ld_val(n, i) ^ 32'h5555);
            check("R8 ready level", {63'd0, lead_st_ready}, (n == D) ? 64'd0 : 64'd1);
            if (n == D) lead_store(32'hFFF8, 32'hBAD0_0000);
            for (int i = 0; i < n; i++) begin
                trail_st_valid = 1;
                trail_st_addr = ld_addr(n, i) + 32'h8000;
                trail_st_data = ld_val(n, i) ^ 32'h5555;
                step();
                check("R6 write valid", {63'd0, mem_wr_valid}, 64'd1);
                check("R11 write addr", {32'd0, mem_wr_addr}, {32'd0, ld_addr(n, i) + 32'h8000});
                check("R11 write data", {32'd0, mem_wr_data}, {32'd0, ld_val(n, i) ^ 32'h5555});
            end
            step();
            check("R6 single write", {63'd0, mem_wr_valid}, 64'd0);
            check("R9 empty", {63'd0, trail_st_ready}, 64'd0);
        end
        trail_st_valid = 1; trail_st_addr = 32'hFFF8; trail_st_data = 32'hBAD0_0000;
        step();
        check("R9 no write on empty", {63'd0, mem_wr_valid}, 64'd0);
        check("R9 no fault on empty", {63'd0, fault}, 64'd0);

        // Store mismatch sweep: flipped address and data bits
        for (int k = 0; k < 6; k++) begin
            logic [31:0] a, d, ta, td;
            a = 32'h3000 + 32'(k * 8);
            d = 32'hC0DE_0000 + 32'(k);
            ta = a; td = d;
            case (k)
                0: ta = a ^ 32'h1;
                1: ta = a ^ 32'h20;
                2: ta = a ^ 32'h8000_0000;
                3: td = d ^ 32'h1;
                4: td = d ^ 32'h100;
                default: td = d ^ 32'h8000_0000;
            endcase
            lead_store(a, d);
            trail_st_valid = 1; trail_st_addr = ta; trail_st_data = td;
            step();
            check("R7 no write", {63'd0, mem_wr_valid}, 64'd0);
            check("R7 fault", {63'd0, fault}, 64'd1);
            check("R7 kind", {62'd0, fault_kind}, 64'd2);
            check("R7 addr", {32'd0, fault_addr}, {32'd0, ta});
            check("R7 freed", {63'd0, trail_st_ready}, 64'd0);
            clear_fault();
        end

        // R10 stickiness across a second fault
        lead_store(32'h4000, 32'h1);
        trail_st_valid = 1; trail_st_addr = 32'h4004; trail_st_data = 32'h1;
        step();
        lead_load(32'h5000, 32'h99);
        trail_ld_valid = 1; trail_ld_addr = 32'h5008;
        step();
        check("R10 sticky kind", {62'd0, fault_kind}, 64'd2);
        check("R10 sticky addr", {32'd0, fault_addr}, 64'h4004);
        clear_fault();

        // R5 load address mismatch
        lead_load(32'h6000, 32'h6666);
        check("R2 data on mismatch", {32'd0, trail_ld_data}, 64'h6666);
        trail_ld_valid = 1; trail_ld_addr = 32'h6010;
        step();
        check("R5 fault", {63'd0, fault}, 64'd1);
        check("R5 kind", {62'd0, fault_kind}, 64'd1);
        check("R5 addr", {32'd0, fault_addr}, 64'h6010);
        check("R5 freed", {63'd0, trail_ld_ready}, 64'd0);

        // R10 clear coinciding with a new fault
        lead_load(32'h7000, 32'h7777);
        fault_clr = 1; trail_ld_valid = 1; trail_ld_addr = 32'h7100;
        step();
        check("R10 clr+event flag", {63'd0, fault}, 64'd1);
        check("R10 clr+event addr", {32'd0, fault_addr}, 64'h7100);
        clear_fault();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule